// File: doc/BRIEF.md
# Squashable Front-End Instruction Queue

This block sits between instruction fetch and dispatch. Fetch offers one instruction per cycle with a payload, a count of destination registers it will rename, and two serialization hints. Each accepted instruction is stamped with the next value of an internal sequence counter. It then spends a fixed number of staging cycles in the queue before dispatch may see it. The block also owns the pool counter of free rename registers. Accepted instructions draw from that pool. Commit returns registers to it, and squashed instructions refund theirs.

A recovery event supplies a sequence number. Every queued instruction younger than that number is discarded from the tail, whether it is still in staging or already visible to dispatch, and its registers go back to the pool. Serialization works in two ways. An instruction can demand that everything after it waits. An instruction marked to go alone is held at the head until the back end reports an empty reorder buffer.

Top module: `fe_inst_queue`

## Requirements
- R1: After synchronous reset the queue is empty (out_valid 0, full 0), the free count equals NUM_PREGS, rename_stall and resume are 0, and in_seq is 0.
- R2: Each accepted instruction (in_valid and in_ready high at a clock edge) is stamped with the value shown on in_seq, which then increases by one. Instructions leave in acceptance order and carry their stamp on out_seq together with their payload and destination count.
- R3: An instruction accepted at the edge closing cycle t is first offered on out_valid in cycle t+LAT+1.
- R4: The queue holds at most DEPTH instructions, counting staging and visible ones together. full is high exactly when DEPTH are held, and in_ready is low while full.
- R5: Each accepted instruction lowers free_regs by its in_dst. rename_stall is high while free_regs is below DST_MAX, and in_ready is low while it is high.
- R6: A commit return (ret_valid high) adds ret_cnt to free_regs, and the result is clamped to NUM_PREGS.
- R7: resume is high for exactly one cycle, the cycle after an edge at which free_regs rose from below DST_MAX to DST_MAX or more.
- R8: With squash_valid high and number N, every held instruction whose stamp is greater than N is removed, whether visible or still staging. Older instructions stay in order. The removed destination counts are added back to free_regs at that edge, with the R6 clamp.
- R9: While squash_valid is high, out_valid and in_ready are both low, so no dequeue and no enqueue happen in a squash cycle.
- R10: An accepted instruction with in_ser_after high causes the next accepted instruction to carry the go-alone mark (out_ser_before 1). The pending request is then consumed, so the instruction after that is unmarked unless it asks on its own.
- R11: An instruction carrying the go-alone mark is not offered on out_valid while rob_empty is low. It is offered once rob_empty is high and is removed when dispatched.
- R12: An accepted instruction with in_ser_before high carries the go-alone mark itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetch offers an instruction |
| in_ready | output | 1 | Queue accepts the offered instruction this cycle |
| in_data | input | DATA_W | Instruction payload |
| in_dst | input | 2 | Destination registers the instruction renames |
| in_ser_before | input | 1 | Instruction must dispatch alone, after the back end drains |
| in_ser_after | input | 1 | Next instruction must dispatch alone |
| in_seq | output | 32 | Stamp the offered instruction would receive |
| out_valid | output | 1 | Head instruction offered to dispatch |
| out_ready | input | 1 | Dispatch takes the head instruction |
| out_data | output | DATA_W | Head payload |
| out_seq | output | 32 | Head stamp |
| out_dst | output | 2 | Head destination count |
| out_ser_before | output | 1 | Head carries the go-alone mark |
| rob_empty | input | 1 | Back end holds no in-flight instructions |
| squash_valid | input | 1 | Discard instructions younger than squash_seq |
| squash_seq | input | 32 | Youngest stamp that survives the squash |
| ret_valid | input | 1 | Commit returns registers |
| ret_cnt | input | clog2(NUM_PREGS+1) | Number of registers returned |
| free_regs | output | clog2(NUM_PREGS+1) | Current free rename register count |
| rename_stall | output | 1 | Too few free registers to accept |
| resume | output | 1 | One-cycle pulse when the register stall ends |
| full | output | 1 | Queue holds DEPTH instructions |

## Verification
The bench squashes when the queue holds a mix of visible and still-staging instructions. An implementation that scans only the visible part would later release the staging ones to dispatch, and one that refunds the wrong entries would end with a wrong free count. It asserts squash together with out_ready on a visible head, so a design that let dequeue win would lose the oldest instruction. It counts the exact cycle in which a newly accepted instruction first appears, so an off-by-one in the staging would show. It also holds a go-alone instruction at the head with the reorder buffer busy, then checks that the instruction after it flows without waiting. A design that kept the serialize request pending, or ignored rob_empty, would fail one of those checks. Register returns are driven past the pool size to catch a missing clamp, and the return that ends a stall is checked for its single resume pulse.

// File: rtl/feq_pkg.sv
package feq_pkg;
    localparam int SEQ_W = 32;
    localparam int DST_W = 2;

    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [DST_W-1:0] dst_t;

    typedef struct packed {
        seq_t seq;
        dst_t dst;
        logic ser_before;
    } slot_t;

    // a is younger than b when its stamp is larger; SEQ_W is wide enough that wrap never occurs
    function automatic logic seq_younger(input seq_t a, input seq_t b);
        return a > b;
    endfunction
endpackage

// File: rtl/feq_store.sv
module feq_store
    import feq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int LAT    = 2,
    parameter int DATA_W = 16,
    parameter int RW     = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push,
    input  slot_t                       push_slot,
    input  logic [DATA_W-1:0]           push_data,
    input  logic                        pop,
    input  logic                        squash,
    input  seq_t                        squash_seq,
    output logic [$clog2(DEPTH+1)-1:0]  occ,
    output logic                        head_vis,
    output slot_t                       head_slot,
    output logic [DATA_W-1:0]           head_data,
    output logic [RW-1:0]               refund
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam int WW = $clog2(LAT+2);

    slot_t             slot_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [WW-1:0]     wait_q [DEPTH];
    logic [PW-1:0]     head_q;
    logic [CW-1:0]     occ_q;
    logic [CW-1:0]     keep_n;
    logic [PW-1:0]     wr_idx;
    logic [PW-1:0]     tail_idx;
    seq_t              head_seq;

    assign wr_idx    = head_q + occ_q[PW-1:0];
    assign tail_idx  = head_q + occ_q[PW-1:0] - PW'(1);
    assign occ       = occ_q;
    assign head_slot = slot_q[head_q];
    assign head_data = data_q[head_q];
    assign head_seq  = slot_q[head_q].seq;
    assign head_vis  = (occ_q != '0) && (wait_q[head_q] == '0);

    // Stamps rise from head to tail, so the survivors form a prefix from the head
    always_comb begin
        keep_n = '0;
        refund = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < occ_q) begin
                if (seq_younger(slot_q[head_q + PW'(i)].seq, squash_seq))
                    refund = refund + RW'(slot_q[head_q + PW'(i)].dst);
                else
                    keep_n = keep_n + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            occ_q  <= '0;
            for (int i = 0; i < DEPTH; i++) wait_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++)
                if (wait_q[i] != '0) wait_q[i] <= wait_q[i] - WW'(1);
            if (squash) begin
                occ_q <= keep_n;
            end else begin
                if (push) begin
                    slot_q[wr_idx] <= push_slot;
                    data_q[wr_idx] <= push_data;
                    wait_q[wr_idx] <= WW'(LAT);
                end
                if (pop) head_q <= head_q + PW'(1);
                occ_q <= occ_q + CW'(push) - CW'(pop);
            end
        end
    end

    p_occupancy_bound_r4: assert property (@(posedge clk) disable iff (rst)
        occ_q <= CW'(DEPTH));

    p_fifo_order_r2: assert property (@(posedge clk) disable iff (rst)
        (pop && !squash && occ_q > CW'(1)) |=> (head_seq > $past(head_seq)));

    p_squash_tail_r8: assert property (@(posedge clk) disable iff (rst)
        squash |=> ((occ_q == '0) || (slot_q[tail_idx].seq <= $past(squash_seq))));
endmodule

// File: rtl/feq_regpool.sv
module feq_regpool
    import feq_pkg::*;
#(
    parameter int NUM_PREGS = 16,
    parameter int DST_MAX   = 2,
    parameter int RW        = 5
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            take,
    input  dst_t                            take_cnt,
    input  logic [RW-1:0]                   give,
    input  logic                            ret_valid,
    input  logic [$clog2(NUM_PREGS+1)-1:0]  ret_cnt,
    output logic [$clog2(NUM_PREGS+1)-1:0]  free,
    output logic                            stall,
    output logic                            resume
);
    localparam int FW = $clog2(NUM_PREGS+1);
    localparam int SW = ((FW > RW) ? FW : RW) + 2;

    logic [FW-1:0] free_q, free_n;
    logic [SW-1:0] sum;
    logic          resume_q;
    logic          stall_n;

    always_comb begin
        sum = SW'(free_q) + SW'(give);
        if (take)      sum = sum - SW'(take_cnt);
        if (ret_valid) sum = sum + SW'(ret_cnt);
        free_n = (sum > SW'(NUM_PREGS)) ? FW'(NUM_PREGS) : FW'(sum);
    end

    assign stall   = free_q < FW'(DST_MAX);
    assign stall_n = free_n < FW'(DST_MAX);
    assign free    = free_q;
    assign resume  = resume_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q   <= FW'(NUM_PREGS);
            resume_q <= 1'b0;
        end else begin
            free_q   <= free_n;
            resume_q <= stall && !stall_n;
        end
    end

    p_free_ceiling_r6: assert property (@(posedge clk) disable iff (rst)
        free_q <= FW'(NUM_PREGS));

    p_resume_edge_r7: assert property (@(posedge clk) disable iff (rst)
        resume_q |-> (!stall && $past(stall)));
endmodule

// File: rtl/fe_inst_queue.sv
module fe_inst_queue
    import feq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int LAT       = 2,
    parameter int DATA_W    = 16,
    parameter int NUM_PREGS = 16,
    parameter int DST_MAX   = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic [DATA_W-1:0]               in_data,
    input  logic [DST_W-1:0]                in_dst,
    input  logic                            in_ser_before,
    input  logic                            in_ser_after,
    output logic [SEQ_W-1:0]                in_seq,
    output logic                            out_valid,
    input  logic                            out_ready,
    output logic [DATA_W-1:0]               out_data,
    output logic [SEQ_W-1:0]                out_seq,
    output logic [DST_W-1:0]                out_dst,
    output logic                            out_ser_before,
    input  logic                            rob_empty,
    input  logic                            squash_valid,
    input  logic [SEQ_W-1:0]                squash_seq,
    input  logic                            ret_valid,
    input  logic [$clog2(NUM_PREGS+1)-1:0]  ret_cnt,
    output logic [$clog2(NUM_PREGS+1)-1:0]  free_regs,
    output logic                            rename_stall,
    output logic                            resume,
    output logic                            full
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int RW = $clog2(DEPTH*((1 << DST_W) - 1) + 1);

    seq_t              seq_q;
    logic              ser_pend_q;
    logic              accept, pop;
    slot_t             new_slot, head_slot;
    logic [CW-1:0]     occ;
    logic              head_vis;
    logic [DATA_W-1:0] head_data;
    logic [RW-1:0]     refund;

    assign full     = (occ == CW'(DEPTH));
    assign in_ready = !full && !squash_valid && !rename_stall;
    assign accept   = in_valid && in_ready;
    assign in_seq   = seq_q;

    assign new_slot.seq        = seq_q;
    assign new_slot.dst        = in_dst;
    assign new_slot.ser_before = in_ser_before | ser_pend_q;

    // Squash wins over dispatch; a go-alone head waits for the back end to drain
    assign out_valid      = head_vis && !squash_valid && (!head_slot.ser_before || rob_empty);
    assign pop            = out_valid && out_ready;
    assign out_data       = head_data;
    assign out_seq        = head_slot.seq;
    assign out_dst        = head_slot.dst;
    assign out_ser_before = head_slot.ser_before;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q      <= '0;
            ser_pend_q <= 1'b0;
        end else if (accept) begin
            seq_q      <= seq_q + SEQ_W'(1);
            ser_pend_q <= in_ser_after;
        end
    end

    feq_store #(.DEPTH(DEPTH), .LAT(LAT), .DATA_W(DATA_W), .RW(RW)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (accept),
        .push_slot  (new_slot),
        .push_data  (in_data),
        .pop        (pop),
        .squash     (squash_valid),
        .squash_seq (squash_seq),
        .occ        (occ),
        .head_vis   (head_vis),
        .head_slot  (head_slot),
        .head_data  (head_data),
        .refund     (refund)
    );

    feq_regpool #(.NUM_PREGS(NUM_PREGS), .DST_MAX(DST_MAX), .RW(RW)) u_pool (
        .clk       (clk),
        .rst       (rst),
        .take      (accept),
        .take_cnt  (in_dst),
        .give      (squash_valid ? refund : '0),
        .ret_valid (ret_valid),
        .ret_cnt   (ret_cnt),
        .free      (free_regs),
        .stall     (rename_stall),
        .resume    (resume)
    );

    p_ser_gate_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ser_before) |-> rob_empty);
endmodule

// File: tb/tb_fe_inst_queue.sv
module tb_fe_inst_queue;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready;
    logic [15:0] in_data;
    logic [1:0]  in_dst;
    logic        in_ser_before, in_ser_after;
    logic [31:0] in_seq;
    logic        out_valid, out_ready;
    logic [15:0] out_data;
    logic [31:0] out_seq;
    logic [1:0]  out_dst;
    logic        out_ser_before;
    logic        rob_empty;
    logic        squash_valid;
    logic [31:0] squash_seq;
    logic        ret_valid;
    logic [4:0]  ret_cnt;
    logic [4:0]  free_regs;
    logic        rename_stall, resume, full;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_seq  = 0;
    int exp_free = 16;
    bit done     = 0;

    always #4 clk = ~clk;

    fe_inst_queue dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_dst(in_dst),
        .in_ser_before(in_ser_before), .in_ser_after(in_ser_after), .in_seq(in_seq),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_seq(out_seq), .out_dst(out_dst), .out_ser_before(out_ser_before),
        .rob_empty(rob_empty), .squash_valid(squash_valid), .squash_seq(squash_seq),
        .ret_valid(ret_valid), .ret_cnt(ret_cnt), .free_regs(free_regs),
        .rename_stall(rename_stall), .resume(resume), .full(full)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic enq(input logic [15:0] d, input logic [1:0] dst,
                       input logic sa, input logic sb);
        in_valid = 1'b1; in_data = d; in_dst = dst;
        in_ser_after = sa; in_ser_before = sb;
        #1;
        check("R2 in_ready on enqueue", in_ready, 1);
        check("R2 stamp offered", in_seq, exp_seq);
        step();
        in_valid = 1'b0; in_ser_after = 1'b0; in_ser_before = 1'b0;
        exp_seq++;
        exp_free -= dst;
    endtask

    task automatic deq(input string tag, input int s, input logic [15:0] d, input logic sb);
        #1;
        for (int k = 0; k < 8 && !out_valid; k++) begin
            @(posedge clk);
            #2;
        end
        check({tag, " out_valid"}, out_valid, 1);
        check({tag, " out_seq"}, out_seq, s);
        check({tag, " out_data"}, out_data, d);
        check({tag, " out_ser_before"}, out_ser_before, sb);
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
    endtask

    task automatic give_back(input int n);
        ret_valid = 1'b1; ret_cnt = 5'(n);
        step();
        ret_valid = 1'b0; ret_cnt = '0;
        exp_free = (exp_free + n > 16) ? 16 : exp_free + n;
    endtask

    task automatic t_reset();
        check("R1 out_valid", out_valid, 0);
        check("R1 full", full, 0);
        check("R1 free_regs", free_regs, 16);
        check("R1 rename_stall", rename_stall, 0);
        check("R1 resume", resume, 0);
        check("R1 in_seq", in_seq, 0);
        check("R1 in_ready", in_ready, 1);
    endtask

    task automatic t_latency();
        int s = exp_seq;
        enq(16'h1111, 2'd1, 0, 0);
        #1 check("R3 hidden t+1", out_valid, 0);
        @(posedge clk); #2 check("R3 hidden t+2", out_valid, 0);
        @(posedge clk); #2 check("R3 visible t+3", out_valid, 1);
        check("R5 free after take", free_regs, exp_free);
        deq("R3", s, 16'h1111, 0);
    endtask

    task automatic t_order();
        int s = exp_seq;
        enq(16'hA000, 2'd0, 0, 0);
        enq(16'hA001, 2'd1, 0, 0);
        enq(16'hA002, 2'd2, 0, 0);
        #1 check("R5 free after three", free_regs, exp_free);
        deq("R2 first", s, 16'hA000, 0);
        check("R2 dst of second", out_dst, 1);
        deq("R2 second", s + 1, 16'hA001, 0);
        deq("R2 third", s + 2, 16'hA002, 0);
    endtask

    task automatic t_full();
        int s = exp_seq;
        for (int i = 0; i < 8; i++) enq(16'hB000 + 16'(i), 2'd1, 0, 0);
        #1 check("R4 full", full, 1);
        check("R4 in_ready low when full", in_ready, 0);
        for (int i = 0; i < 8; i++) deq("R4 drain", s + i, 16'hB000 + 16'(i), 0);
        check("R4 full cleared", full, 0);
        give_back(31);
        #1 check("R6 clamp to pool size", free_regs, 16);
    endtask

    task automatic t_stall();
        int s = exp_seq;
        for (int i = 0; i < 4; i++) enq(16'hC000 + 16'(i), 2'd2, 0, 0);
        for (int i = 0; i < 4; i++) deq("R5 drain a", s + i, 16'hC000 + 16'(i), 0);
        s = exp_seq;
        for (int i = 0; i < 4; i++) enq(16'hC100 + 16'(i), 2'd2, 0, 0);
        #1 check("R5 free exhausted", free_regs, 0);
        check("R5 rename_stall", rename_stall, 1);
        in_valid = 1'b1;
        #1 check("R5 in_ready low on stall", in_ready, 0);
        in_valid = 1'b0;
        give_back(1);
        #1 check("R7 still stalled", rename_stall, 1);
        check("R7 no resume yet", resume, 0);
        give_back(3);
        #1 check("R7 resume pulse", resume, 1);
        check("R6 free after return", free_regs, 4);
        step();
        check("R7 resume one cycle", resume, 0);
        for (int i = 0; i < 4; i++) deq("R5 drain b", s + i, 16'hC100 + 16'(i), 0);
        give_back(12);
        #1 check("R6 free restored", free_regs, exp_free);
    endtask

    task automatic t_squash_mixed();
        int s = exp_seq;
        for (int i = 0; i < 5; i++) enq(16'hD000 + 16'(i), 2'd1, 0, 0);
        squash_valid = 1'b1; squash_seq = 32'(s + 1); out_ready = 1'b1;
        #1 check("R9 out_valid low in squash", out_valid, 0);
        check("R9 in_ready low in squash", in_ready, 0);
        step();
        squash_valid = 1'b0; out_ready = 1'b0;
        exp_free += 3;
        check("R8 refund", free_regs, exp_free);
        deq("R9 head kept", s, 16'hD000, 0);
        deq("R8 survivor", s + 1, 16'hD001, 0);
        repeat (4) step();
        check("R8 staged victims gone", out_valid, 0);
    endtask

    task automatic t_squash_all();
        int s = exp_seq;
        enq(16'hE000, 2'd2, 0, 0);
        enq(16'hE001, 2'd2, 0, 0);
        squash_valid = 1'b1; squash_seq = 32'(s - 1);
        step();
        squash_valid = 1'b0;
        exp_free += 4;
        check("R8 refund all", free_regs, exp_free);
        repeat (4) step();
        check("R8 nothing left", out_valid, 0);
        enq(16'hE002, 2'd1, 0, 0);
        deq("R2 stamp continues", s + 2, 16'hE002, 0);
    endtask

    task automatic t_serialize();
        int s = exp_seq;
        rob_empty = 1'b0;
        enq(16'hF000, 2'd0, 1, 0);
        enq(16'hF001, 2'd0, 0, 0);
        enq(16'hF002, 2'd0, 0, 0);
        enq(16'hF003, 2'd0, 0, 1);
        deq("R10 requester", s, 16'hF000, 0);
        repeat (3) step();
        check("R11 held while rob busy", out_valid, 0);
        rob_empty = 1'b1;
        deq("R10 marked follower", s + 1, 16'hF001, 1);
        rob_empty = 1'b0;
        deq("R10 request consumed", s + 2, 16'hF002, 0);
        repeat (3) step();
        check("R12 own mark held", out_valid, 0);
        rob_empty = 1'b1;
        deq("R12 own mark", s + 3, 16'hF003, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 0; in_data = 0; in_dst = 0;
        in_ser_before = 0; in_ser_after = 0; out_ready = 0; rob_empty = 1;
        squash_valid = 0; squash_seq = 0; ret_valid = 0; ret_cnt = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        t_reset();
        t_latency();
        t_order();
        t_full();
        t_stall();
        t_squash_mixed();
        t_squash_all();
        t_serialize();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule